// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block converts a virtual address, given as a segment number plus a displacement, into a physical main-store address. It fetches segment descriptors from memory through a single read port. The top bit of the segment number picks one of two tables. One is a per-process local table and the other is a shared public table. Each table is located by its own base input. The remaining segment-number bits index the chosen table.

A local descriptor may be marked as a redirect. In that case its base field holds the memory address of a descriptor in a shared global table. The block then fetches that second descriptor and judges the translation on it alone. Every translation ends with a one-cycle completion pulse. The pulse carries a result code and, on success, the physical address. The possible results are success, segment absent, displacement beyond the segment length, and malformed descriptor chain.

Top module: `seg_addr_xlat`

## Requirements
- R1: While reset is held and right after it, `xl_done_o` and `tr_req_o` are low.
- R2: When `xl_seg_i[13]` is 0, the first descriptor read goes to `lt_base_i + xl_seg_i[12:0]`. When it is 1, the first read goes to `pt_base_i + xl_seg_i[12:0]`.
- R3: A 44-bit descriptor has the following fields. Bits [23:0] hold the base, bits [41:24] the length, bit 42 the redirect marker and bit 43 the presence marker.
- R4: Result codes are 0 = ok, 1 = absent, 2 = bound, 3 = format. On ok, `xl_paddr_o` equals base + displacement.
- R5: A judged descriptor whose presence marker is 0 gives code 1, and `xl_paddr_o` is 0.
- R6: A displacement strictly greater than the length gives code 2. A displacement equal to the length is ok. Every non-ok result shows `xl_paddr_o` = 0.
- R7: A local descriptor with the redirect marker set causes a second read at its base field. The presence, length and base of the second descriptor decide the result, and the local descriptor's presence and length are ignored.
- R8: A redirect marker found in a public descriptor or in a second-level (global) descriptor gives code 3.
- R9: At most one read is outstanding. `tr_req_o` is a one-cycle pulse, and no new pulse is issued until `tr_valid_i` has returned the previous read.
- R10: `xl_done_o` is a one-cycle pulse in the cycle after the final `tr_valid_i`. While a translation is in flight, `xl_req_i` is ignored.
- R11: The checks have a fixed priority. Format is checked first, then absent, then bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_req_i | input | 1 | Start a translation (taken only when idle) |
| xl_seg_i | input | 14 | Segment number |
| xl_disp_i | input | 18 | Displacement within segment |
| lt_base_i | input | 24 | Local table base address |
| pt_base_i | input | 24 | Public table base address |
| tr_req_o | output | 1 | Descriptor read request pulse |
| tr_addr_o | output | 24 | Descriptor read address |
| tr_valid_i | input | 1 | Read data valid |
| tr_data_i | input | 44 | Descriptor word |
| xl_done_o | output | 1 | Translation complete pulse |
| xl_code_o | output | 2 | Result code |
| xl_paddr_o | output | 24 | Physical address (0 unless ok) |

## Verification
A request accepted on one edge raises `tr_req_o` for the following cycle. The result is due exactly one cycle after the last read returns, whatever latency the memory model applies. The memory model records the cycle in which it raises valid. The bench then requires the completion pulse at the next sample point, followed by a low sample one cycle after that. Read latency varies between vectors so that the timing is tested against several delays. Inputs change only on falling edges and outputs are sampled there, so each comparison sees settled registered values.

// File: rtl/segx_pkg.sv
package segx_pkg;

    typedef enum logic [1:0] {
        XC_OK     = 2'd0,
        XC_ABSENT = 2'd1,
        XC_BOUND  = 2'd2,
        XC_FORMAT = 2'd3
    } xcode_e;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_REQ  = 2'd1,
        XS_WAIT = 2'd2
    } xstate_e;

endpackage

// File: rtl/segx_tbl_sel.sv
module segx_tbl_sel #(
    parameter int SEG_W = 14,
    parameter int AW    = 24
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [AW-1:0]    lbase_i,
    input  logic [AW-1:0]    pbase_i,
    output logic [AW-1:0]    addr_o,
    output logic             pub_o
);
    localparam int IDX_W = SEG_W - 1;

    logic [AW-1:0] idx_ext;

    always_comb begin
        pub_o   = seg_i[SEG_W-1];
        idx_ext = {{(AW-IDX_W){1'b0}}, seg_i[IDX_W-1:0]};
        addr_o  = (pub_o ? pbase_i : lbase_i) + idx_ext;
    end
endmodule

// File: rtl/segx_entry_unpack.sv
module segx_entry_unpack #(
    parameter int LEN_W = 18,
    parameter int AW    = 24
) (
    input  logic [AW+LEN_W+1:0] word_i,
    output logic                present_o,
    output logic                redir_o,
    output logic [LEN_W-1:0]    len_o,
    output logic [AW-1:0]       base_o
);
    localparam int EW = AW + LEN_W + 2;

    always_comb begin
        present_o = word_i[EW-1];
        redir_o   = word_i[EW-2];
        len_o     = word_i[AW+LEN_W-1:AW];
        base_o    = word_i[AW-1:0];
    end
endmodule

// File: rtl/segx_entry_judge.sv
module segx_entry_judge
    import segx_pkg::*;
#(
    parameter int DISP_W = 18,
    parameter int LEN_W  = 18,
    parameter int AW     = 24
) (
    input  logic              present_i,
    input  logic              redir_i,
    input  logic              deny_redir_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [AW-1:0]     base_i,
    input  logic [DISP_W-1:0] disp_i,
    output xcode_e            code_o,
    output logic [AW-1:0]     paddr_o
);
    localparam int CW = (DISP_W > LEN_W) ? DISP_W : LEN_W;

    logic [CW-1:0] disp_c;
    logic [CW-1:0] len_c;

    always_comb begin
        disp_c  = CW'(disp_i);
        len_c   = CW'(len_i);
        paddr_o = '0;
        if (redir_i && deny_redir_i) begin
            code_o = XC_FORMAT;
        end else if (!present_i) begin
            code_o = XC_ABSENT;
        end else if (disp_c > len_c) begin
            code_o = XC_BOUND;
        end else begin
            code_o  = XC_OK;
            paddr_o = base_i + {{(AW-DISP_W){1'b0}}, disp_i};
        end
    end
endmodule

// File: rtl/seg_addr_xlat.sv
module seg_addr_xlat
    import segx_pkg::*;
#(
    parameter int SEG_W  = 14,
    parameter int DISP_W = 18,
    parameter int LEN_W  = 18,
    parameter int AW     = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    xl_req_i,
    input  logic [SEG_W-1:0]        xl_seg_i,
    input  logic [DISP_W-1:0]       xl_disp_i,
    input  logic [AW-1:0]           lt_base_i,
    input  logic [AW-1:0]           pt_base_i,
    output logic                    tr_req_o,
    output logic [AW-1:0]           tr_addr_o,
    input  logic                    tr_valid_i,
    input  logic [AW+LEN_W+1:0]     tr_data_i,
    output logic                    xl_done_o,
    output logic [1:0]              xl_code_o,
    output logic [AW-1:0]           xl_paddr_o
);
    typedef struct packed {
        xstate_e           st;
        logic              second;
        logic              pub;
        logic [DISP_W-1:0] disp;
        logic [AW-1:0]     addr;
        logic              done;
        xcode_e            code;
        logic [AW-1:0]     paddr;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0]    sel_addr;
    logic             sel_pub;
    logic             ent_present;
    logic             ent_redir;
    logic [LEN_W-1:0] ent_len;
    logic [AW-1:0]    ent_base;
    xcode_e           j_code;
    logic [AW-1:0]    j_paddr;

    segx_tbl_sel #(.SEG_W(SEG_W), .AW(AW)) sel_i (
        .seg_i   (xl_seg_i),
        .lbase_i (lt_base_i),
        .pbase_i (pt_base_i),
        .addr_o  (sel_addr),
        .pub_o   (sel_pub)
    );

    segx_entry_unpack #(.LEN_W(LEN_W), .AW(AW)) unp_i (
        .word_i    (tr_data_i),
        .present_o (ent_present),
        .redir_o   (ent_redir),
        .len_o     (ent_len),
        .base_o    (ent_base)
    );

    segx_entry_judge #(.DISP_W(DISP_W), .LEN_W(LEN_W), .AW(AW)) jdg_i (
        .present_i    (ent_present),
        .redir_i      (ent_redir),
        .deny_redir_i (r_q.second | r_q.pub),
        .len_i        (ent_len),
        .base_i       (ent_base),
        .disp_i       (r_q.disp),
        .code_o       (j_code),
        .paddr_o      (j_paddr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            XS_IDLE: begin
                if (xl_req_i) begin
                    r_d.st     = XS_REQ;
                    r_d.second = 1'b0;
                    r_d.pub    = sel_pub;
                    r_d.disp   = xl_disp_i;
                    r_d.addr   = sel_addr;
                end
            end
            XS_REQ: begin
                r_d.st = XS_WAIT;
            end
            XS_WAIT: begin
                if (tr_valid_i) begin
                    if (ent_redir && !r_q.second && !r_q.pub) begin
                        r_d.st     = XS_REQ;
                        r_d.second = 1'b1;
                        r_d.addr   = ent_base;
                    end else begin
                        r_d.st    = XS_IDLE;
                        r_d.done  = 1'b1;
                        r_d.code  = j_code;
                        r_d.paddr = j_paddr;
                    end
                end
            end
            default: begin
                r_d.st = XS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tr_req_o   = (r_q.st == XS_REQ);
    assign tr_addr_o  = r_q.addr;
    assign xl_done_o  = r_q.done;
    assign xl_code_o  = r_q.code;
    assign xl_paddr_o = r_q.paddr;

endmodule

// File: rtl/segx_chk.sv
module segx_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tr_req_o,
    input logic          tr_valid_i,
    input logic          xl_done_o,
    input logic [1:0]    xl_code_o,
    input logic [AW-1:0] xl_paddr_o
);
    logic outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (tr_req_o) begin
            outst_q <= 1'b1;
        end else if (tr_valid_i) begin
            outst_q <= 1'b0;
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tr_req_o |=> !tr_req_o); // R9
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        tr_req_o |-> !outst_q); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done_o |=> !xl_done_o); // R10
    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done_o |-> $past(tr_valid_i)); // R10
    AST_FAIL_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done_o && xl_code_o != 2'd0) |-> xl_paddr_o == '0); // R5
    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done_o |-> !tr_req_o); // R10

endmodule

bind seg_addr_xlat segx_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tr_req_o   (tr_req_o),
    .tr_valid_i (tr_valid_i),
    .xl_done_o  (xl_done_o),
    .xl_code_o  (xl_code_o),
    .xl_paddr_o (xl_paddr_o)
);

// File: tb/seg_addr_xlat_tb_top.sv
module seg_addr_xlat_tb_top;

    localparam int NV = 12;
    localparam int VW = 84;

    // seg, disp, first read addr, reads, code, paddr
    localparam logic [VW-1:0] VECS [0:NV-1] = '{
        {14'h0000, 18'd5,      24'd16, 2'd1, 2'd0, 24'h001005},
        {14'h0000, 18'd100,    24'd16, 2'd1, 2'd0, 24'h001064},
        {14'h0000, 18'd101,    24'd16, 2'd1, 2'd2, 24'h000000},
        {14'h0001, 18'd0,      24'd17, 2'd1, 2'd1, 24'h000000},
        {14'h0002, 18'd7,      24'd18, 2'd2, 2'd0, 24'h003007},
        {14'h0002, 18'd21,     24'd18, 2'd2, 2'd2, 24'h000000},
        {14'h0003, 18'd0,      24'd19, 2'd2, 2'd1, 24'h000000},
        {14'h0004, 18'd9,      24'd20, 2'd2, 2'd3, 24'h000000},
        {14'h0005, 18'd9,      24'd21, 2'd1, 2'd1, 24'h000000},
        {14'h2002, 18'h3FFFF,  24'd66, 2'd1, 2'd0, 24'h83FFFF},
        {14'h2003, 18'd0,      24'd67, 2'd1, 2'd3, 24'h000000},
        {14'h2000, 18'd0,      24'd64, 2'd1, 2'd1, 24'h000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_req_i = 1'b0;
    logic [13:0] xl_seg_i = '0;
    logic [17:0] xl_disp_i = '0;
    logic [23:0] lt_base_i = 24'd16;
    logic [23:0] pt_base_i = 24'd64;
    logic        tr_req_o;
    logic [23:0] tr_addr_o;
    logic        tr_valid_i = 1'b0;
    logic [43:0] tr_data_i = '0;
    logic        xl_done_o;
    logic [1:0]  xl_code_o;
    logic [23:0] xl_paddr_o;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int lat = 1;
    int nreads = 0;
    int vcyc = 0;
    int ndone = 0;
    int ovl = 0;
    logic pend = 1'b0;
    logic prev_req = 1'b0;
    logic [23:0] rd_log [0:63];
    logic [43:0] mem [0:255];

    always #4 clk = ~clk;

    seg_addr_xlat dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .xl_req_i   (xl_req_i),
        .xl_seg_i   (xl_seg_i),
        .xl_disp_i  (xl_disp_i),
        .lt_base_i  (lt_base_i),
        .pt_base_i  (pt_base_i),
        .tr_req_o   (tr_req_o),
        .tr_addr_o  (tr_addr_o),
        .tr_valid_i (tr_valid_i),
        .tr_data_i  (tr_data_i),
        .xl_done_o  (xl_done_o),
        .xl_code_o  (xl_code_o),
        .xl_paddr_o (xl_paddr_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) if (rst_n && xl_done_o) ndone <= ndone + 1;

    // R9 monitor: one outstanding, single-cycle request
    always @(posedge clk) begin
        if (rst_n) begin
            if (tr_valid_i) pend = 1'b0;
            if (tr_req_o) begin
                if (pend || prev_req) ovl = ovl + 1;
                pend = 1'b1;
            end
            prev_req = tr_req_o;
        end
    end

    // memory model
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && tr_req_o) begin
                logic [23:0] a;
                a = tr_addr_o;
                rd_log[nreads % 64] = a;
                nreads = nreads + 1;
                repeat (lat) @(negedge clk);
                tr_data_i  = mem[a[7:0]];
                tr_valid_i = 1'b1;
                vcyc = cyc;
                @(negedge clk);
                tr_valid_i = 1'b0;
            end
        end
    end

    function automatic logic [43:0] mk(input logic p, input logic r,
                                       input logic [17:0] len, input logic [23:0] base);
        return {p, r, len, base};
    endfunction

    task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    // waits for done; returns 0 on timeout
    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (xl_done_o) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        nchk = nchk + 1;
        nerr = nerr + 1;
        $display("FAIL R10 watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        bit got;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // R3 layout: [23:0] base, [41:24] length, 42 redirect, 43 present
        mem[16]  = mk(1'b1, 1'b0, 18'd100, 24'h001000);
        mem[17]  = mk(1'b0, 1'b0, 18'd50,  24'h002000);
        mem[18]  = mk(1'b0, 1'b1, 18'd0,   24'd128);
        mem[128] = mk(1'b1, 1'b0, 18'd20,  24'h003000);
        mem[19]  = mk(1'b0, 1'b1, 18'd0,   24'd129);
        mem[129] = mk(1'b0, 1'b0, 18'd20,  24'h004000);
        mem[20]  = mk(1'b1, 1'b1, 18'd0,   24'd130);
        mem[130] = mk(1'b1, 1'b1, 18'd0,   24'h005000);
        mem[21]  = mk(1'b0, 1'b0, 18'd3,   24'h000500);
        mem[64]  = mk(1'b0, 1'b0, 18'd10,  24'h000700);
        mem[66]  = mk(1'b1, 1'b0, 18'h3FFFF, 24'h800000);
        mem[67]  = mk(1'b1, 1'b1, 18'd50,  24'h000600);

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(xl_done_o == 1'b0, "R1 done in reset", 32'(xl_done_o), 0);
        chk(tr_req_o == 1'b0, "R1 read req in reset", 32'(tr_req_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xl_done_o == 1'b0 && tr_req_o == 1'b0, "R1 after reset", 32'({xl_done_o, tr_req_o}), 0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            int r0, d0, dc;
            v   = VECS[i];
            lat = 1 + (i % 3);
            r0  = nreads;
            xl_seg_i  = v[83:70];
            xl_disp_i = v[69:52];
            xl_req_i  = 1'b1;
            @(negedge clk);
            xl_req_i = 1'b0;
            wait_done(got);
            chk(got, "R10 no completion", 0, 1);
            dc = cyc;
            d0 = vcyc;
            chk(dc == d0 + 1, "R10 done one cycle after last valid", 32'(dc - d0), 1);
            chk(xl_code_o == v[25:24], "R3 R4 R5 R6 R8 R11 result code", 32'(xl_code_o), 32'(v[25:24]));
            chk(xl_paddr_o == v[23:0], "R4 R6 physical address", 32'(xl_paddr_o), 32'(v[23:0]));
            chk(nreads - r0 == int'(v[27:26]), "R7 read count", 32'(nreads - r0), 32'(v[27:26]));
            chk(rd_log[r0 % 64] == v[51:28], "R2 first table address", 32'(rd_log[r0 % 64]), 32'(v[51:28]));
            @(negedge clk);
            chk(xl_done_o == 1'b0, "R10 done pulse width", 32'(xl_done_o), 0);
        end

        // R10: requests while busy are ignored
        begin
            int n0;
            lat = 3;
            n0 = ndone;
            xl_seg_i  = 14'h0000;
            xl_disp_i = 18'd5;
            xl_req_i  = 1'b1;
            @(negedge clk);
            xl_seg_i  = 14'h0001;
            repeat (3) @(negedge clk);
            xl_req_i = 1'b0;
            wait_done(got);
            chk(got && xl_code_o == 2'd0, "R10 first request kept code", 32'(xl_code_o), 0);
            chk(xl_paddr_o == 24'h001005, "R10 first request kept paddr", 32'(xl_paddr_o), 32'h1005);
            repeat (20) @(negedge clk);
            chk(ndone - n0 == 1, "R10 busy request ignored", 32'(ndone - n0), 1);
        end

        chk(ovl == 0, "R9 read overlap or long pulse", 32'(ovl), 0);

        summary();
        $finish;
    end

endmodule